// File: doc/BRIEF.md
# Accelerator Power Status Registers

This block holds two 64-bit memory-mapped registers that sit in an accelerator port's register space. The first is a control word. Software sets a single latency-tolerance flag in it, and the block drives that flag out to the rest of the port. The same word also shows a read-only soft-reset acknowledge that hardware supplies.

The second is a status word. It mirrors the power and throttling level that an external throttling controller reports. It also keeps two sticky event flags. Each flag records that the controller entered one of the two partial throttling levels at some point, even if it stayed there for a single clock. Software polls the status word, learns that a short throttling episode happened, and writes 1 to the flag to acknowledge it.

Access goes through a plain register bus: a byte address, a write strobe with 64-bit data, and a read strobe. Read data is registered and returns one cycle after the strobe. The reset input is asynchronous and active low. Inside the block its release is synchronized to the clock.

Top module: `accel_pwr_regs`

## Requirements
- R1: After reset, the latency-tolerance output is 0, both event flags are 0 and the read data is 0.
- R2: The control word is at byte address 0x38. Bit 2 of it is the latency-tolerance flag (1 = can tolerate 40 us or more, 0 = latency sensitive). A write to 0x38 loads that bit from write-data bit 2. The value appears on `lat_tol_out` in the cycle after the write and reads back at bit 2.
- R3: Control bit 4 reads the soft-reset acknowledge input, registered once. Writes do not affect it. All other control bits read 0, whatever was written.
- R4: The status word is at byte address 0x40. Bits 11:8 show the power-state input, registered once (0 normal, 1 level one at 50 %, 2 level two at 90 %, 6 full throttle). Bus writes never change this field.
- R5: Status bit 12 sets on any clock edge where the power-state input equals 1, even for a single cycle. It stays set after the state leaves 1.
- R6: Status bit 13 sets on any clock edge where the power-state input equals 2, even for a single cycle. It stays set after the state leaves 2.
- R7: Writing 1 to status bit 12 or bit 13 clears only that flag. Writing 0 to a flag leaves it unchanged.
- R8: When a flag's set condition and a write-1 clear of that flag fall on the same edge, the flag ends up set.
- R9: A read strobe captures the addressed word at the clock edge, so read data is valid one cycle later. Without a strobe, the read data holds its last value, even when the registers change.
- R10: Only the exact byte addresses 0x38 and 0x40 are decoded. Reads of any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Byte address of the access |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 64 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rd_data | output | 64 | Registered read data, valid one cycle after the strobe |
| pwr_state_in | input | 4 | Power/throttle level from the throttling controller |
| rst_ack_in | input | 1 | Hardware soft-reset acknowledge |
| lat_tol_out | output | 1 | Latched latency-tolerance flag |

## Verification
The bench sweeps all sixteen power-state codes as one-cycle pulses and as held levels. A design that decoded the levels loosely would flag events for codes such as 3 or 6, and one that sampled the state late would miss the single-cycle pulses.

A clear is issued in the same cycle as a set condition. If clear took priority, the event would be silently lost. Write-0 and write-to-the-state-field cases catch designs that clear a flag or overwrite the mirrored state on any write.

Every one of the 256 byte addresses is written with all ones and read back. This exposes a partial address decode, which would alias 0x39 or 0xB8 onto a real register. Finally, the read data is watched across register changes with no strobe, to catch a read path that is combinational instead of captured.

// File: rtl/accel_pwr_pkg.sv
package accel_pwr_pkg;
  // Bit positions software decodes; these stay fixed.
  localparam int CTRL_LAT_BIT = 2;
  localparam int CTRL_ACK_BIT = 4;
  localparam int STS_PWR_LSB  = 8;
  localparam int STS_EVT_LSB  = 12;
  // Event flag g tracks throttle level g+1.
  localparam int NUM_EVT      = 2;
endpackage

// File: rtl/accel_pwr_rst_sync.sv
module accel_pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/accel_pwr_ctrl_reg.sv
module accel_pwr_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic lat_wr_bit,
  input  logic ack_in,
  output logic lat_q,
  output logic ack_q
);
  logic lat_en;
  logic lat_d;
  logic ack_d;

  always_comb begin
    lat_en = wr_hit;
    lat_d  = lat_wr_bit;
    ack_d  = ack_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      if (lat_en) lat_q <= lat_d;
      ack_q <= ack_d;
    end
  end

  assert_lat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(lat_q));
  assert_lat_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> lat_q == $past(lat_wr_bit));
  assert_ack_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ack_q == $past(ack_in));
endmodule

// File: rtl/accel_pwr_sts_reg.sv
module accel_pwr_sts_reg #(
  parameter int PS_W    = 4,
  parameter int NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PS_W-1:0]    pwr_in,
  input  logic               wr_hit,
  input  logic [NUM_EVT-1:0] clr_bits,
  output logic [PS_W-1:0]    pwr_q,
  output logic [NUM_EVT-1:0] evt_q
);
  logic [PS_W-1:0]    pwr_d;
  logic [NUM_EVT-1:0] set_w;
  logic [NUM_EVT-1:0] clr_w;
  logic [NUM_EVT-1:0] evt_d;

  always_comb pwr_d = pwr_in;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    localparam logic [PS_W-1:0] LVL = PS_W'(g + 1);
    assign set_w[g] = (pwr_in == LVL);
    assign clr_w[g] = wr_hit & clr_bits[g];
    // Set has priority over a write-1 clear.
    assign evt_d[g] = set_w[g] | (evt_q[g] & ~clr_w[g]);

    // g=0 covers R5, g=1 covers R6
    assert_evt_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_w[g] |=> evt_q[g]);
    assert_evt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q[g] && !clr_w[g] |=> evt_q[g]);
    assert_evt_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w[g] && !set_w[g] |=> !evt_q[g]);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_w[g] && clr_w[g] |=> evt_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= '0;
      evt_q <= '0;
    end else begin
      pwr_q <= pwr_d;
      evt_q <= evt_d;
    end
  end

  assert_pwr_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pwr_q == $past(pwr_in));
endmodule

// File: rtl/accel_pwr_rd_mux.sv
module accel_pwr_rd_mux
  import accel_pwr_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int PS_W    = 4,
  parameter int NEVT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              ctrl_hit,
  input  logic              sts_hit,
  input  logic              lat,
  input  logic              ack,
  input  logic [PS_W-1:0]   pwr,
  input  logic [NEVT-1:0]   evt,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] sts_word;
  logic [DATA_W-1:0] rd_d;
  logic              rd_ce;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_LAT_BIT] = lat;
    ctrl_word[CTRL_ACK_BIT] = ack;
    sts_word = '0;
    sts_word[STS_PWR_LSB +: PS_W] = pwr;
    sts_word[STS_EVT_LSB +: NEVT] = evt;
    rd_ce = rd_en;
    if (ctrl_hit)     rd_d = ctrl_word;
    else if (sts_hit) rd_d = sts_word;
    else              rd_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_ce) rd_q <= rd_d;
  end

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));
  assert_rd_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !ctrl_hit && !sts_hit |=> rd_q == '0);
  assert_rd_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && ctrl_hit |=> rd_q[CTRL_LAT_BIT] == $past(lat));
endmodule

// File: rtl/accel_pwr_regs.sv
module accel_pwr_regs
  import accel_pwr_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 64,
  parameter int              PS_W       = 4,
  parameter int              RST_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(8'h38),
  parameter logic [ADDR_W-1:0] STS_OFS  = ADDR_W'(8'h40)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              reg_rd_en,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic [PS_W-1:0]   pwr_state_in,
  input  logic              rst_ack_in,
  output logic              lat_tol_out
);
  logic               rst_int_n;
  logic               ctrl_hit;
  logic               sts_hit;
  logic               lat_q;
  logic               ack_q;
  logic [PS_W-1:0]    pwr_q;
  logic [NUM_EVT-1:0] evt_q;
  logic               unused_wr_bits;

  assign ctrl_hit       = (reg_addr == CTRL_OFS);
  assign sts_hit        = (reg_addr == STS_OFS);
  assign unused_wr_bits = ^reg_wr_data;

  accel_pwr_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  accel_pwr_ctrl_reg ctrl_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_hit     (reg_wr_en & ctrl_hit),
    .lat_wr_bit (reg_wr_data[CTRL_LAT_BIT]),
    .ack_in     (rst_ack_in),
    .lat_q      (lat_q),
    .ack_q      (ack_q)
  );

  accel_pwr_sts_reg #(.PS_W(PS_W), .NUM_EVT(NUM_EVT)) sts_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pwr_in   (pwr_state_in),
    .wr_hit   (reg_wr_en & sts_hit),
    .clr_bits (reg_wr_data[STS_EVT_LSB +: NUM_EVT]),
    .pwr_q    (pwr_q),
    .evt_q    (evt_q)
  );

  accel_pwr_rd_mux #(.DATA_W(DATA_W), .PS_W(PS_W), .NEVT(NUM_EVT)) rd_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_en    (reg_rd_en),
    .ctrl_hit (ctrl_hit),
    .sts_hit  (sts_hit),
    .lat      (lat_q),
    .ack      (ack_q),
    .pwr      (pwr_q),
    .evt      (evt_q),
    .rd_q     (reg_rd_data)
  );

  assign lat_tol_out = lat_q;

  assert_unmapped_wr_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    reg_wr_en && !ctrl_hit |=> $stable(lat_tol_out));
endmodule

// File: tb/accel_pwr_regs_tb.sv
`timescale 1ns/1ps
module accel_pwr_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr_en;
  logic [63:0] reg_wr_data;
  logic        reg_rd_en;
  logic [63:0] reg_rd_data;
  logic [3:0]  pwr_state_in;
  logic        rst_ack_in;
  logic        lat_tol_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  accel_pwr_regs dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_data  (reg_wr_data),
    .reg_rd_en    (reg_rd_en),
    .reg_rd_data  (reg_rd_data),
    .pwr_state_in (pwr_state_in),
    .rst_ack_in   (rst_ack_in),
    .lat_tol_out  (lat_tol_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rd_data;
  endtask

  function automatic logic [63:0] sts_exp(input int fld, input bit e1, input bit e2);
    return (64'(fld) << 8) | (64'(e1) << 12) | (64'(e2) << 13);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rv;
    logic [63:0] held;
    rst_n = 1'b0; reg_addr = '0; reg_wr_en = 1'b0; reg_wr_data = '0;
    reg_rd_en = 1'b0; pwr_state_in = '0; rst_ack_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 lat", 64'(lat_tol_out), 64'd0);
    chk("R1 rd_data", reg_rd_data, 64'd0);
    bus_rd(8'h40, rv);
    chk("R1 status", rv, 64'd0);

    // R2/R3 control word
    bus_wr(8'h38, '1);
    chk("R2 lat set", 64'(lat_tol_out), 64'd1);
    bus_rd(8'h38, rv);
    chk("R3 ctrl other bits zero", rv, 64'h4);
    rst_ack_in = 1'b1;
    bus_rd(8'h38, rv);
    chk("R3 ack visible", rv, 64'h14);
    bus_wr(8'h38, 64'h0);
    chk("R2 lat clear", 64'(lat_tol_out), 64'd0);
    bus_rd(8'h38, rv);
    chk("R3 ack unaffected by write", rv, 64'h10);
    rst_ack_in = 1'b0;
    bus_wr(8'h38, 64'h4);
    bus_rd(8'h38, rv);
    chk("R2 rmw single bit", rv, 64'h4);
    bus_wr(8'h38, 64'h0);

    // R4/R5/R6 sweep of every power code: pulse then hold
    for (int v = 0; v < 16; v++) begin
      bus_wr(8'h40, 64'h3000);
      @(negedge clk); pwr_state_in = 4'(v);
      @(negedge clk); pwr_state_in = 4'd0;
      bus_rd(8'h40, rv);
      chk("R5 R6 one-cycle pulse", rv, sts_exp(0, v == 1, v == 2));
      @(negedge clk); pwr_state_in = 4'(v);
      bus_rd(8'h40, rv);
      chk("R4 field mirrors held state", rv, sts_exp(v, v == 1, v == 2));
      bus_wr(8'h40, 64'hF00);
      bus_rd(8'h40, rv);
      chk("R4 field ignores write", rv, sts_exp(v, v == 1, v == 2));
      pwr_state_in = 4'd0;
    end

    // R7 clear behaviour
    bus_wr(8'h40, 64'h3000);
    @(negedge clk); pwr_state_in = 4'd1;
    @(negedge clk); pwr_state_in = 4'd2;
    @(negedge clk); pwr_state_in = 4'd0;
    bus_wr(8'h40, 64'h0);
    bus_rd(8'h40, rv);
    chk("R7 write 0 keeps flags", rv, 64'h3000);
    bus_wr(8'h40, 64'h2000);
    bus_rd(8'h40, rv);
    chk("R7 clear bit13 only", rv, 64'h1000);
    bus_wr(8'h40, 64'h1000);
    bus_rd(8'h40, rv);
    chk("R7 clear bit12", rv, 64'h0);

    // R8 set beats clear in the same cycle
    @(negedge clk);
    pwr_state_in = 4'd1; reg_addr = 8'h40; reg_wr_data = 64'h3000; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; pwr_state_in = 4'd0;
    bus_rd(8'h40, rv);
    chk("R8 level1 set wins", rv, 64'h1000);
    @(negedge clk);
    pwr_state_in = 4'd2; reg_addr = 8'h40; reg_wr_data = 64'h3000; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; pwr_state_in = 4'd0;
    bus_rd(8'h40, rv);
    chk("R8 level2 set wins, bit12 cleared", rv, 64'h2000);
    bus_wr(8'h40, 64'h3000);

    // R9 read data holds without a strobe
    bus_wr(8'h38, 64'h4);
    bus_rd(8'h38, held);
    bus_wr(8'h38, 64'h0);
    @(negedge clk); pwr_state_in = 4'd1;
    @(negedge clk); pwr_state_in = 4'd0;
    repeat (2) @(negedge clk);
    chk("R9 rd_data held", reg_rd_data, held);
    bus_rd(8'h40, rv);
    chk("R9 fresh read", rv, 64'h1000);
    bus_wr(8'h40, 64'h3000);

    // R10 full address sweep
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h38 && a != 8'h40) begin
        bus_wr(8'(a), '1);
        bus_rd(8'(a), rv);
        chk("R10 unmapped read zero", rv, 64'h0);
      end
    end
    chk("R10 lat untouched", 64'(lat_tol_out), 64'd0);
    bus_rd(8'h40, rv);
    chk("R10 status untouched", rv, 64'h0);
    bus_rd(8'h38, rv);
    chk("R10 ctrl untouched", rv, 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule